// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits between the host bus of a flash memory model and its internal operation engine. It watches the active-low chip-enable, write-enable and output-enable strobes. It turns each completed bus write into a command, and it keeps track of which kind of data a read should return: array contents, configuration/identifier words, the status register, or query data. The command interface has no address of its own. Commands go on the data bus and the address bus is ignored, except where it carries the target of a program or erase.

Program and block erase each take two bus writes. The second write supplies the operands. When the sequence is accepted, the block sends a one-cycle start pulse to the engine along with the captured address and data. It then reports busy in the status register until the engine raises its done flag. While an operation is under way, it can be suspended and resumed. A program can also run while an erase is suspended. Any command that is malformed sets an error flag in the status register.

Top module: `flash_cmd_iface`

## Requirements
- R1: After reset, rd_mode is 0 (array), status is 80h, both start pulses are low and susp_hold is low.
- R2: A bus write exists only while ce_n and we_n are both low and oe_n is high. Strobe activity with oe_n low, or with ce_n high, changes nothing.
- R3: A write takes effect on the clock edge after the strobes release. Its command byte, address and data are the values present during the last cycle in which the strobes were active. The address never selects the command interface.
- R4: Writing 40h and then any byte gives a one-cycle prog_start, with op_addr and op_data taken from the second write. Status bit 7 (ready) reads 0 until op_done.
- R5: Writing 20h and then D0h gives a one-cycle erase_start, with op_addr taken from the second write. If the second byte is not D0h, no start occurs, status bit 4 (sequence error) is set and rd_mode becomes 2.
- R6: While an operation is busy, rd_mode is 2 (status) and every write other than B0h is ignored.
- R7: When op_done arrives, status bit 7 returns to 1 and rd_mode stays at 2 until FFh is written, which selects rd_mode 0.
- R8: When no operation is busy, 90h selects rd_mode 1 (configuration), 98h selects 3 (query), 70h selects 2 (status) and FFh selects 0 (array).
- R9: An unrecognised byte in the first cycle sets status bit 4 and selects rd_mode 2. The byte 50h clears bit 4.
- R10: B0h during an erase gives status C0h (ready with bit 6, erase-suspended) and raises susp_hold. op_done is ignored while suspended. Read commands work. D0h resumes the erase, clearing bits 7 and 6 and lowering susp_hold.
- R11: While an erase is suspended, 40h followed by a data byte starts a program. Status reads 40h and susp_hold is low. On op_done the block returns to the erase-suspended state, with status C0h and susp_hold high.
- R12: B0h during a program gives status 84h (bit 2, program-suspended) with susp_hold high. Program or erase commands in this state set bit 4. D0h resumes the program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Bus address |
| din | input | 8 | Bus write data |
| op_done | input | 1 | Engine finished the current operation |
| rd_mode | output | 2 | Read source: 0 array, 1 configuration, 2 status, 3 query |
| susp_hold | output | 1 | Engine must stay paused |
| prog_start | output | 1 | One-cycle program start |
| erase_start | output | 1 | One-cycle erase start |
| op_addr | output | AW | Operand address for the engine |
| op_data | output | 8 | Operand data for the engine |
| status | output | 8 | Status register: bit 7 ready, bit 6 erase-suspended, bit 4 sequence error, bit 2 program-suspended |

## Verification
The sequencer is exercised with single-cycle read commands, with both two-cycle sequences given valid and invalid second bytes, and with an unknown opcode. Together these separate the accepted paths from the error path. Busy windows receive stray commands and a spurious done, which shows whether the block filters writes correctly by state. Suspend and resume of both operation kinds, plus a program nested inside an erase suspend, check that the right prior state is restored. Writes with output-enable low or chip-enable high, and operands that change once the strobes release, show whether the block qualifies bus writes and captures their operands correctly.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_CONFIG = 2'd1,
    RM_STATUS = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PSETUP,
    S_ESETUP,
    S_PBUSY,
    S_EBUSY,
    S_PSUSP,
    S_ESUSP,
    S_EPSETUP,
    S_EPBUSY
  } cui_state_e;

  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_RDARR   = 8'hFF;
  localparam logic [7:0] OP_RDSTAT  = 8'h70;
  localparam logic [7:0] OP_CLRSTAT = 8'h50;
  localparam logic [7:0] OP_RDCFG   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_SUSP    = 8'hB0;
  localparam logic [7:0] OP_CONF    = 8'hD0;

  function automatic logic is_read_op(input logic [7:0] op);
    return (op == OP_RDARR) || (op == OP_RDSTAT) ||
           (op == OP_RDCFG) || (op == OP_QUERY);
  endfunction

  function automatic rd_mode_e mode_for(input logic [7:0] op);
    case (op)
      OP_RDARR: return RM_ARRAY;
      OP_RDCFG: return RM_CONFIG;
      OP_QUERY: return RM_QUERY;
      default:  return RM_STATUS;
    endcase
  endfunction

  function automatic logic is_busy(input cui_state_e s);
    return (s == S_PBUSY) || (s == S_EBUSY) || (s == S_EPBUSY);
  endfunction

  function automatic logic erase_held(input cui_state_e s);
    return (s == S_ESUSP) || (s == S_EPSETUP) || (s == S_EPBUSY);
  endfunction

  function automatic logic [7:0] pack_status(input logic ready, input logic esusp,
                                             input logic seqerr, input logic psusp);
    return {ready, esusp, 1'b0, seqerr, 1'b0, psusp, 2'b00};
  endfunction

endpackage

// File: rtl/fcmd_wr_detect.sv
module fcmd_wr_detect #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          commit,
  output logic [AW-1:0] c_addr,
  output logic [7:0]    c_data
);
  logic strobe;
  logic strobe_q;

  assign strobe = !ce_n && !we_n && oe_n;
  assign commit = strobe_q && !strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      c_addr   <= '0;
      c_data   <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe) begin
        c_addr <= addr;
        c_data <= din;
      end
    end
  end
endmodule

// File: rtl/fcmd_seq.sv
module fcmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [AW-1:0] c_addr,
  input  logic [7:0]    c_data,
  input  logic          op_done,
  output cui_state_e    state,
  output rd_mode_e      mode_q,
  output logic          prog_start,
  output logic          erase_start,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic          err_set,
  output logic          err_clr
);
  cui_state_e    nxt;
  rd_mode_e      mode_n;
  logic          ps_n, es_n;
  logic [AW-1:0] addr_n;
  logic [7:0]    data_n;

  always_comb begin
    nxt     = state;
    mode_n  = mode_q;
    ps_n    = 1'b0;
    es_n    = 1'b0;
    addr_n  = op_addr;
    data_n  = op_data;
    err_set = 1'b0;
    err_clr = 1'b0;
    case (state)
      S_IDLE: if (commit) begin
        if (is_read_op(c_data)) mode_n = mode_for(c_data);
        else if (c_data == OP_CLRSTAT) err_clr = 1'b1;
        else if (c_data == OP_PROG) begin
          nxt = S_PSETUP; mode_n = RM_STATUS;
        end else if (c_data == OP_ERASE) begin
          nxt = S_ESETUP; mode_n = RM_STATUS;
        end else if (c_data != OP_SUSP && c_data != OP_CONF) begin
          err_set = 1'b1; mode_n = RM_STATUS;
        end
      end
      S_PSETUP: if (commit) begin
        ps_n = 1'b1; addr_n = c_addr; data_n = c_data; nxt = S_PBUSY;
      end
      S_ESETUP: if (commit) begin
        if (c_data == OP_CONF) begin
          es_n = 1'b1; addr_n = c_addr; data_n = c_data; nxt = S_EBUSY;
        end else begin
          err_set = 1'b1; nxt = S_IDLE;
        end
        mode_n = RM_STATUS;
      end
      S_PBUSY: begin
        if (op_done) nxt = S_IDLE;
        else if (commit && c_data == OP_SUSP) nxt = S_PSUSP;
      end
      S_EBUSY: begin
        if (op_done) nxt = S_IDLE;
        else if (commit && c_data == OP_SUSP) nxt = S_ESUSP;
      end
      S_PSUSP: if (commit) begin
        if (is_read_op(c_data)) mode_n = mode_for(c_data);
        else if (c_data == OP_CLRSTAT) err_clr = 1'b1;
        else if (c_data == OP_CONF) begin
          nxt = S_PBUSY; mode_n = RM_STATUS;
        end else if (c_data != OP_SUSP) begin
          err_set = 1'b1; mode_n = RM_STATUS;
        end
      end
      S_ESUSP: if (commit) begin
        if (is_read_op(c_data)) mode_n = mode_for(c_data);
        else if (c_data == OP_CLRSTAT) err_clr = 1'b1;
        else if (c_data == OP_CONF) begin
          nxt = S_EBUSY; mode_n = RM_STATUS;
        end else if (c_data == OP_PROG) begin
          nxt = S_EPSETUP; mode_n = RM_STATUS;
        end else if (c_data != OP_SUSP) begin
          err_set = 1'b1; mode_n = RM_STATUS;
        end
      end
      S_EPSETUP: if (commit) begin
        ps_n = 1'b1; addr_n = c_addr; data_n = c_data; nxt = S_EPBUSY;
      end
      S_EPBUSY: if (op_done) nxt = S_ESUSP;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      mode_q      <= RM_ARRAY;
      prog_start  <= 1'b0;
      erase_start <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
    end else begin
      state       <= nxt;
      mode_q      <= mode_n;
      prog_start  <= ps_n;
      erase_start <= es_n;
      op_addr     <= addr_n;
      op_data     <= data_n;
    end
  end
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cui_state_e state,
  input  logic       err_set,
  input  logic       err_clr,
  output logic [7:0] status
);
  logic seqerr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seqerr <= 1'b0;
    else if (err_set) seqerr <= 1'b1;
    else if (err_clr) seqerr <= 1'b0;
  end

  assign status = pack_status(!is_busy(state), erase_held(state), seqerr,
                              state == S_PSUSP);
endmodule

// File: rtl/flash_cmd_iface.sv
module flash_cmd_iface
  import flash_cmd_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          op_done,
  output logic [1:0]    rd_mode,
  output logic          susp_hold,
  output logic          prog_start,
  output logic          erase_start,
  output logic [AW-1:0] op_addr,
  output logic [7:0]    op_data,
  output logic [7:0]    status
);
  logic          wr_commit;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  cui_state_e    state;
  rd_mode_e      mode_q;
  logic          err_set, err_clr;

  fcmd_wr_detect #(.AW(AW)) u_wr (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .commit(wr_commit), .c_addr(wr_addr), .c_data(wr_data)
  );

  fcmd_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .commit(wr_commit), .c_addr(wr_addr), .c_data(wr_data),
    .op_done(op_done), .state(state), .mode_q(mode_q), .prog_start(prog_start),
    .erase_start(erase_start), .op_addr(op_addr), .op_data(op_data),
    .err_set(err_set), .err_clr(err_clr)
  );

  fcmd_status u_stat (
    .clk(clk), .rst_n(rst_n), .state(state), .err_set(err_set), .err_clr(err_clr),
    .status(status)
  );

  assign rd_mode   = is_busy(state) ? RM_STATUS : mode_q;
  assign susp_hold = (state == S_PSUSP) || (state == S_ESUSP) || (state == S_EPSETUP);
endmodule

// File: rtl/fcmd_checker.sv
module fcmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_start,
  input logic       erase_start,
  input logic [7:0] status,
  input logic [1:0] rd_mode,
  input logic       susp_hold,
  input logic       wr_commit,
  input logic [7:0] wr_data
);
  p_start_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_start && erase_start));
  p_prog_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_start || erase_start) |-> !status[7]);
  p_erase_confirm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(wr_commit && wr_data == 8'hD0));
  p_busy_reads_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !status[7] |-> rd_mode == 2'd2);
  p_hold_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    susp_hold |-> status[7]);
endmodule

bind flash_cmd_iface fcmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .prog_start(prog_start), .erase_start(erase_start),
  .status(status), .rd_mode(rd_mode), .susp_hold(susp_hold),
  .wr_commit(wr_commit), .wr_data(wr_data)
);

// File: tb/test_flash_cmd_iface.sv
module test_flash_cmd_iface;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          op_done = 1'b0;
  logic [1:0]    rd_mode;
  logic          susp_hold, prog_start, erase_start;
  logic [AW-1:0] op_addr;
  logic [7:0]    op_data, status;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  flash_cmd_iface #(.AW(AW)) i_flash_cmd_iface (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .din(din), .op_done(op_done), .rd_mode(rd_mode), .susp_hold(susp_hold),
    .prog_start(prog_start), .erase_start(erase_start), .op_addr(op_addr),
    .op_data(op_data), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_gen(input logic [AW-1:0] a, input logic [7:0] d,
                        input logic ce, input logic oe);
    @(negedge clk); ce_n = ce; we_n = 1'b0; oe_n = oe; addr = a; din = d;
    @(negedge clk);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = ~a; din = ~d;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    wr_gen(a, d, 1'b0, 1'b1);
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", rd_mode, 0); chk("R1 status", status, 8'h80);
    chk("R1 starts", {prog_start, erase_start}, 0); chk("R1 hold", susp_hold, 0);
  endtask

  task automatic t_qualify();
    wr_gen(16'h0003, 8'h70, 1'b0, 1'b0);
    chk("R2 oe low ignored", rd_mode, 0);
    wr_gen(16'h0003, 8'h90, 1'b1, 1'b1);
    chk("R2 ce high ignored", rd_mode, 0);
  endtask

  task automatic t_read_modes();
    wr(16'hABCD, 8'h90); chk("R8 config", rd_mode, 1);
    wr(16'h0000, 8'h98); chk("R8 query", rd_mode, 3);
    wr(16'h7777, 8'h70); chk("R8 status", rd_mode, 2);
    wr(16'h0001, 8'hFF); chk("R8 array", rd_mode, 0);
  endtask

  task automatic t_bad_opcode();
    wr(0, 8'h33); chk("R9 err bit", status, 8'h90); chk("R9 mode", rd_mode, 2);
    wr(0, 8'h50); chk("R9 clear", status, 8'h80);
    wr(0, 8'hFF);
  endtask

  task automatic t_program();
    wr(16'h0042, 8'h40);
    chk("R4 no early start", prog_start, 0); chk("R4 setup status", rd_mode, 2);
    wr(16'h1234, 8'hA5);
    chk("R4 pulse", prog_start, 1); chk("R3 addr", op_addr, 16'h1234);
    chk("R3 data", op_data, 8'hA5); chk("R4 busy", status, 8'h00);
    @(negedge clk); chk("R4 one cycle", prog_start, 0);
    wr(0, 8'hFF); chk("R6 mode while busy", rd_mode, 2);
    wr(0, 8'h33); chk("R6 ignored", status, 8'h00);
    done_pulse(); chk("R7 ready", status, 8'h80); chk("R7 stays status", rd_mode, 2);
    wr(0, 8'hFF); chk("R7 array", rd_mode, 0);
  endtask

  task automatic t_erase();
    wr(0, 8'h20); wr(16'h0400, 8'hD0);
    chk("R5 pulse", erase_start, 1); chk("R5 addr", op_addr, 16'h0400);
    chk("R5 busy", status, 8'h00);
    done_pulse(); chk("R5 done", status, 8'h80);
    wr(0, 8'h20); wr(16'h0500, 8'hFF);
    chk("R5 no start", erase_start, 0); chk("R5 err", status, 8'h90);
    chk("R5 mode", rd_mode, 2);
    wr(0, 8'h50); wr(0, 8'hFF);
  endtask

  task automatic t_erase_suspend();
    wr(0, 8'h20); wr(16'h0800, 8'hD0);
    wr(0, 8'hB0);
    chk("R10 status", status, 8'hC0); chk("R10 hold", susp_hold, 1);
    wr(0, 8'hFF); chk("R10 read array", rd_mode, 0);
    done_pulse(); chk("R10 done ignored", status, 8'hC0);
    wr(0, 8'h40); wr(16'h0010, 8'h3C);
    chk("R11 pulse", prog_start, 1); chk("R11 data", op_data, 8'h3C);
    chk("R11 status", status, 8'h40); chk("R11 hold low", susp_hold, 0);
    chk("R11 mode", rd_mode, 2);
    done_pulse(); chk("R11 back", status, 8'hC0); chk("R11 hold", susp_hold, 1);
    wr(0, 8'hD0); chk("R10 resume", status, 8'h00); chk("R10 unhold", susp_hold, 0);
    done_pulse(); chk("R10 finish", status, 8'h80);
    wr(0, 8'hFF);
  endtask

  task automatic t_prog_suspend();
    wr(0, 8'h40); wr(16'h0020, 8'h11);
    wr(0, 8'hB0);
    chk("R12 status", status, 8'h84); chk("R12 hold", susp_hold, 1);
    wr(0, 8'h20); chk("R12 err", status, 8'h94); chk("R12 mode", rd_mode, 2);
    wr(0, 8'h50); chk("R12 clear", status, 8'h84);
    wr(0, 8'hD0); chk("R12 resume", status, 8'h00); chk("R12 unhold", susp_hold, 0);
    done_pulse(); chk("R12 finish", status, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_qualify();
    t_read_modes();
    t_bad_opcode();
    t_program();
    t_erase();
    t_erase_suspend();
    t_prog_suspend();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule